// File: doc/BRIEF.md
# Fractional-N Oversampling and Sampling Tick Generator

This block turns a fast input clock into two enable pulses. The oversampling tick arrives on average once every M + S·N/125 input clocks. The sampling tick arrives once every 125 oversampling ticks. M is the integer part of the ratio. N is a fractional numerator. S is a sign that either lengthens or shortens some periods by one input clock.

In each sampling frame, N of the 125 oversampling periods last M+S clocks and the others last M clocks. An error accumulator spreads the altered periods as evenly as the count allows, which keeps period jitter low. The altered count is exact in every frame, so each frame is a fixed whole number of input clocks, 125·M + S·N. Settings are taken only at a frame boundary. Settings that are not allowed are forced to a safe value.

Downstream logic uses the two outputs as clock enables, one for the oversampled datapath and one for the sample-rate datapath.

Top module: `frac_os_tickgen`

## Requirements
- R1: While rst_n is low, os_tick and fs_tick are 0. After rst_n goes high, the first os_tick is high in the cycle after the M-th rising clock edge.
- R2: Every sampling frame, measured from one fs_tick pulse to the next, lasts exactly 125·M + S·N input clocks. S is +1 when sign_neg=0 and −1 when sign_neg=1.
- R3: Each frame holds exactly 125 oversampling periods. N of them last M+S clocks and 125−N of them last M clocks. No period has any other length.
- R4: When N = 0, every oversampling period lasts exactly M clocks.
- R5: Within a frame, the distance in periods between two successive altered periods is either floor(125/N) or ceil(125/N).
- R6: fs_tick is high only together with the os_tick that ends the 125th period of a frame. fs_tick is never high in two consecutive cycles.
- R7: A change on m_int, n_frac or sign_neg in the middle of a frame leaves the length of that frame unchanged. The new setting applies from the next frame. This also holds when the change arrives in the last cycle of a frame.
- R8: Illegal settings are forced to safe ones. M = 0 runs as M = 1. M = 1 runs with N = 0 and S = +1. M = 2 runs with S = +1 and keeps its N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset; must be released synchronously to clk |
| m_int | input | MW (7) | Integer divide part M, legal range 1..64 |
| n_frac | input | NW (6) | Fractional numerator N over 125, legal range 0..62 |
| sign_neg | input | 1 | Sign of the fraction: 0 lengthens altered periods by one clock, 1 shortens them by one clock |
| os_tick | output | 1 | One-clock oversampling enable pulse |
| fs_tick | output | 1 | One-clock sampling enable pulse, once per 125 oversampling pulses |

## Verification
Two things can land on the same clock edge. One is the end of a sampling frame, where the 125th period wraps and the new settings are captured. The other is a change on the setting inputs. The bench provokes this by changing m_int, n_frac and sign_neg at the falling edge just before the closing edge of a frame. It then checks that the closing frame keeps its old length and that the next frame has the new length and the new altered-period count. The same edge also joins the oversampling and sampling pulses, and every frame measurement checks that os_tick is high whenever fs_tick is.

// File: rtl/frac_os_pkg.sv
package frac_os_pkg;

  // Fixed oversampling ratio (frame length in oversampling periods).
  localparam int FOS_DEN_DEFAULT = 125;

  // Sign of the fractional correction.
  typedef enum logic {
    FOS_SIGN_PLUS  = 1'b0,
    FOS_SIGN_MINUS = 1'b1
  } fos_sign_e;

endpackage

// File: rtl/fos_cfg_hold.sv
// Sanitizes the setting inputs and holds them for a whole frame.
module fos_cfg_hold #(
  parameter int MW = 7,
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_in,
  input  logic [NW-1:0] n_in,
  input  logic          neg_in,
  input  logic          load,
  output logic [MW-1:0] m_eff,
  output logic [NW-1:0] n_eff,
  output logic          neg_eff,
  output logic          started
);
  import frac_os_pkg::*;

  logic [MW-1:0] m_s, m_q;
  logic [NW-1:0] n_s, n_q;
  logic          neg_s, neg_q;
  logic          started_q;
  logic          cap_en;

  // Safe-setting mapping.
  always_comb begin
    m_s   = (m_in == '0) ? MW'(1) : m_in;
    n_s   = (m_s == MW'(1)) ? '0 : n_in;
    neg_s = (m_s <= MW'(2)) ? FOS_SIGN_PLUS : neg_in;
  end

  assign cap_en = !started_q || load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q       <= '0;
      n_q       <= '0;
      neg_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (cap_en) begin
        m_q   <= m_s;
        n_q   <= n_s;
        neg_q <= neg_s;
      end
    end
  end

  // First frame after reset runs straight from the inputs.
  always_comb begin
    m_eff   = started_q ? m_q   : m_s;
    n_eff   = started_q ? n_q   : n_s;
    neg_eff = started_q ? neg_q : neg_s;
  end

  assign started = started_q;

endmodule

// File: rtl/fos_spread_acc.sv
// Error accumulator deciding which periods are altered.
module fos_spread_acc #(
  parameter int NW  = 6,
  parameter int DEN = 125
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NW-1:0]            n_eff,
  input  logic                     step,
  input  logic                     clear,
  output logic                     alt,
  output logic [$clog2(DEN)-1:0]   acc_val
);
  localparam int AW = $clog2(DEN);
  localparam int SW = AW + 1;

  logic [AW-1:0] acc_q, acc_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, acc_q} + SW'(n_eff);
    alt = (sum >= SW'(DEN));
    if (clear)
      acc_d = '0;
    else if (step)
      acc_d = alt ? AW'(sum - SW'(DEN)) : sum[AW-1:0];
    else
      acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_val = acc_q;

endmodule

// File: rtl/fos_period_ctr.sv
// Counts input clocks of the current oversampling period.
module fos_period_ctr #(
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_eff,
  input  logic          neg_eff,
  input  logic          alt,
  output logic          wrap
);
  import frac_os_pkg::*;

  localparam int CW = MW + 1;

  logic [CW-1:0] len, cnt_q, cnt_d;

  always_comb begin
    len = {1'b0, m_eff};
    if (alt)
      len = (neg_eff == FOS_SIGN_MINUS) ? len - CW'(1) : len + CW'(1);
    wrap  = (cnt_q == len - CW'(1));
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fos_frame_ctr.sv
// Counts oversampling periods within a frame.
module fos_frame_ctr #(
  parameter int DEN = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic last
);
  localparam int FW = $clog2(DEN);

  logic [FW-1:0] idx_q, idx_d;
  logic          at_end;

  always_comb begin
    at_end = (idx_q == FW'(DEN - 1));
    last   = step && at_end;
    if (step) idx_d = at_end ? '0 : idx_q + FW'(1);
    else      idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/frac_os_tickgen.sv
module frac_os_tickgen #(
  parameter int MW  = 7,
  parameter int NW  = 6,
  parameter int DEN = frac_os_pkg::FOS_DEN_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_int,
  input  logic [NW-1:0] n_frac,
  input  logic          sign_neg,
  output logic          os_tick,
  output logic          fs_tick
);
  localparam int AW = $clog2(DEN);

  logic [MW-1:0] m_eff;
  logic [NW-1:0] n_eff;
  logic          neg_eff;
  logic          started;
  logic          alt;
  logic          wrap;
  logic          frame_end;
  logic [AW-1:0] acc_val;
  logic          os_q, fs_q;

  fos_cfg_hold #(.MW(MW), .NW(NW)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .m_in(m_int), .n_in(n_frac), .neg_in(sign_neg),
    .load(frame_end),
    .m_eff(m_eff), .n_eff(n_eff), .neg_eff(neg_eff), .started(started)
  );

  fos_spread_acc #(.NW(NW), .DEN(DEN)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .n_eff(n_eff), .step(wrap), .clear(frame_end),
    .alt(alt), .acc_val(acc_val)
  );

  fos_period_ctr #(.MW(MW)) per_i (
    .clk(clk), .rst_n(rst_n),
    .m_eff(m_eff), .neg_eff(neg_eff), .alt(alt),
    .wrap(wrap)
  );

  fos_frame_ctr #(.DEN(DEN)) frm_i (
    .clk(clk), .rst_n(rst_n),
    .step(wrap), .last(frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q <= 1'b0;
      fs_q <= 1'b0;
    end else begin
      os_q <= wrap;
      fs_q <= frame_end;
    end
  end

  assign os_tick = os_q;
  assign fs_tick = fs_q;

endmodule

// File: rtl/frac_os_tickgen_chk.sv
module frac_os_tickgen_chk #(
  parameter int MW  = 7,
  parameter int NW  = 6,
  parameter int DEN = 125
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   os_tick,
  input logic                   fs_tick,
  input logic                   frame_end,
  input logic                   started,
  input logic [MW-1:0]          m_eff,
  input logic [NW-1:0]          n_eff,
  input logic                   neg_eff,
  input logic [$clog2(DEN)-1:0] acc_val
);

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!os_tick && !fs_tick); // R1
  end

  AST_FS_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tick |-> os_tick); // R6

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tick |=> !fs_tick); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !frame_end) |=> $stable({m_eff, n_eff, neg_eff})); // R7

  AST_SAFE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eff != '0) && ((m_eff != MW'(1)) || (n_eff == '0))
    && ((m_eff > MW'(2)) || !neg_eff)); // R8

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_val) < DEN); // R5

endmodule

bind frac_os_tickgen frac_os_tickgen_chk #(.MW(MW), .NW(NW), .DEN(DEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .fs_tick(fs_tick),
  .frame_end(frame_end), .started(started),
  .m_eff(m_eff), .n_eff(n_eff), .neg_eff(neg_eff), .acc_val(acc_val)
);

// File: tb/frac_os_tickgen_tb_top.sv
module frac_os_tickgen_tb_top;
  localparam int MW  = 7;
  localparam int NW  = 6;
  localparam int DEN = 125;

  logic          clk;
  logic          rst_n;
  logic [MW-1:0] m_int;
  logic [NW-1:0] n_frac;
  logic          sign_neg;
  logic          os_tick;
  logic          fs_tick;

  int tests  = 0;
  int errors = 0;
  bit done   = 0;

  frac_os_tickgen #(.MW(MW), .NW(NW), .DEN(DEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_int(m_int), .n_frac(n_frac),
    .sign_neg(sign_neg), .os_tick(os_tick), .fs_tick(fs_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int n, input bit neg);
    m_int    = MW'(m);
    n_frac   = NW'(n);
    sign_neg = neg;
  endtask

  task automatic wait_fs();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!fs_tick && k < 20000);
    if (!fs_tick) check(1'b0, "R6 fs timeout", k, 0);
  endtask

  // Measures one frame; call right after an fs_tick was sampled.
  task automatic measure_frame(input int em, input int en, input bit eneg, input string tag);
    int cyc = 0, last = 0, nos = 0, nalt = 0, prev_alt = 0;
    int bad_len = 0, bad_gap = 0, plen, gap;
    int s = eneg ? -1 : 1;
    int glo = (en > 0) ? DEN / en : 0;
    int ghi = (en > 0) ? (DEN + en - 1) / en : 0;
    int exp_len = DEN * em + s * en;
    bit os_at_fs = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (os_tick) begin
        nos++;
        plen = cyc - last;
        last = cyc;
        if (plen == em) begin
        end else if (plen == em + s) begin
          nalt++;
          if (prev_alt > 0) begin
            gap = nos - prev_alt;
            if (gap != glo && gap != ghi) bad_gap++;
          end
          prev_alt = nos;
        end else bad_len++;
      end
      if (fs_tick) begin
        os_at_fs = os_tick;
        break;
      end
      if (cyc > 20000) break;
    end
    check(cyc == exp_len, {tag, " R2 frame length"}, cyc, exp_len);
    check(nos == DEN, {tag, " R3 periods per frame"}, nos, DEN);
    check(nalt == en, {tag, " R3 altered periods"}, nalt, en);
    check(bad_len == 0, {tag, " R3 R4 period length"}, bad_len, 0);
    check(bad_gap == 0, {tag, " R5 altered spacing"}, bad_gap, 0);
    check(os_at_fs, {tag, " R6 fs with os"}, int'(os_at_fs), 1);
  endtask

  // Applies a setting mid-frame, lets the current frame close, then measures.
  task automatic run_cfg(input int m, input int n, input bit neg,
                         input int em, input int en, input bit eneg, input string tag);
    set_cfg(m, n, neg);
    wait_fs();
    measure_frame(em, en, eneg, tag);
  endtask

  task automatic t_reset();
    set_cfg(5, 0, 1'b0);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!os_tick && !fs_tick, "R1 quiet in reset", int'(os_tick | fs_tick), 0);
    end
    rst_n = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check(os_tick == (k == 5), "R1 first os after M edges", int'(os_tick), int'(k == 5));
      check(!fs_tick, "R6 no fs on first period", int'(fs_tick), 0);
    end
    wait_fs();
    measure_frame(5, 0, 1'b0, "R1 first frame R4");
  endtask

  task automatic t_fraction();
    run_cfg(8, 17, 1'b0, 8, 17, 1'b0, "plus M8 N17");
    run_cfg(3, 62, 1'b1, 3, 62, 1'b1, "minus M3 N62");
    run_cfg(64, 1, 1'b1, 64, 1, 1'b1, "minus M64 N1");
    run_cfg(2, 62, 1'b0, 2, 62, 1'b0, "plus M2 N62");
  endtask

  task automatic t_sweep();
    int ms[3] = '{3, 9, 17};
    int ns[4] = '{0, 1, 25, 62};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 2; k++)
          run_cfg(ms[i], ns[j], k[0], ms[i], ns[j], k[0], "sweep R2");
  endtask

  task automatic t_sanitize();
    run_cfg(1, 40, 1'b1, 1, 0, 1'b0, "R8 M1 forces N0");
    run_cfg(2, 30, 1'b1, 2, 30, 1'b0, "R8 M2 forces plus");
    run_cfg(0, 20, 1'b1, 1, 0, 1'b0, "R8 M0 as M1");
  endtask

  task automatic t_change();
    int cyc;
    run_cfg(6, 10, 1'b0, 6, 10, 1'b0, "R7 base");
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 100) set_cfg(4, 30, 1'b1);
    end while (!fs_tick && cyc < 20000);
    check(cyc == 760, "R7 mid-frame change keeps length", cyc, 760);
    measure_frame(4, 30, 1'b1, "R7 new setting next frame");
    // Change in the very last cycle of a frame (470 clocks long).
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 469) set_cfg(9, 5, 1'b0);
    end while (!fs_tick && cyc < 20000);
    check(cyc == 470, "R7 last-cycle change keeps length", cyc, 470);
    measure_frame(9, 5, 1'b0, "R7 last-cycle change applies");
  endtask

  initial begin
    rst_n = 1'b0;
    set_cfg(5, 0, 1'b0);
    t_reset();
    t_fraction();
    t_sanitize();
    t_change();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 195000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  end

endmodule